// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block moves one voice sample per frame across a three-wire serial link made of a bit clock, a frame sync and a data line in each direction. It runs from a single fast system clock and treats the bit clock and frame sync as ordinary signals that it samples or generates. When the `master` input is high it generates both lines itself: 256 bit clocks per frame, each bit clock lasting `2*HALF_DIV` system clocks. When `master` is low it follows a bit clock and frame sync supplied from outside.

A frame begins in one of two ways. With long-frame sync, the rising edge of the sync line is bit 0. With short-frame sync, a one-bit-wide pulse is sampled on a falling bit-clock edge, and the next rising edge is bit 0. A programmable offset places the sample's time slot inside the frame, and the slot is 8 or 16 bits long. Inside the slot the port shifts out a sample that it latched at the start of the frame, most significant bit first. The output is open-drain, so it only ever pulls the line low. In the same slot the port shifts in serial data on the falling bit-clock edges and hands the completed word to the parallel side with a single-cycle strobe.

Top module: `pcm_tdm_port`

## Requirements
- R1: After reset, `bclk_out`, `fsync_out`, `dout_lo`, `tx_slot` and `rx_valid` are 0 and `rx_data` is 0.
- R2: With `master`=1 and `pwrdn`=0, `bclk_out` has a period of 2*HALF_DIV system clocks (4 by default). There are exactly FRAME_BITS (256) bit-clock rising edges from one frame-sync rising edge to the next.
- R3: In master mode with long sync (`short_fs`=0), `fsync_out` rises together with the bit-clock rise of bit 0 and stays high for W bit clocks. With short sync (`short_fs`=1), it is high for exactly one bit-clock period, from the rise of the last bit (FRAME_BITS-1) to the rise of bit 0. W is 8 when `wide`=0 and 16 when `wide`=1.
- R4: With `master`=0 the port is timed only from `bclk_in` and `fsync_in`, and `bclk_out` and `fsync_out` stay 0.
- R5: In long-sync mode a rising edge of the frame sync sets the bit index to 0. In short-sync mode, the first bit-clock rise after a falling bit-clock edge that sampled the frame sync high sets the bit index to 0. Every other bit-clock rise advances the index by one.
- R6: `tx_slot` is 1 exactly while the bit index lies in [`slot_off`, `slot_off`+W). It follows a bit-clock rise one system clock later.
- R7: At slot position k (0 = first bit), `dout_lo` is the inverse of bit W-1-k of the transmit sample. `dout_lo` is never 1 outside the slot, so a 1 bit releases the line.
- R8: `din` is sampled on each falling bit-clock edge inside the slot, most significant bit first. One system clock after the falling edge of the last slot bit, `rx_valid` pulses for one cycle. At that point `rx_data` holds the word, right-justified with the upper 8 bits 0 when W=8. Otherwise `rx_data` holds its value.
- R9: The bit index stops at FRAME_BITS-1. Slot bits that would fall past the frame end are neither driven nor received, and a clipped slot gives no `rx_valid`.
- R10: With `en`=0, `tx_slot` and `dout_lo` stay 0 and no `rx_valid` occurs.
- R11: With `pwrdn`=1, `bclk_out` and `fsync_out` are held 0 and the port neither drives nor receives.
- R12: The transmit sample is copied from `tx_hold` at frame start. Changing `tx_hold` later in the frame does not change the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master | input | 1 | 1: generate bit clock and frame sync; 0: accept them |
| short_fs | input | 1 | 0: long-frame sync; 1: short-frame sync |
| wide | input | 1 | 0: 8-bit samples; 1: 16-bit samples |
| en | input | 1 | Enables the serial data path |
| pwrdn | input | 1 | Power-down: stops clock generation and the data path |
| slot_off | input | 8 | Slot start, in bit clocks from frame start |
| bclk_in | input | 1 | External bit clock (slave mode) |
| fsync_in | input | 1 | External frame sync (slave mode) |
| din | input | 1 | Serial receive data |
| tx_hold | input | 16 | Transmit sample holding register (low 8 bits used when W=8) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| fsync_out | output | 1 | Generated frame sync (master mode) |
| dout_lo | output | 1 | Open-drain pull-low enable for the serial output |
| tx_slot | output | 1 | High while the port owns its time slot |
| rx_data | output | 16 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe when `rx_data` is updated |

## Verification
A wrong bit index shows on `tx_slot` within one bit-clock period, because the slot window moves to the wrong bits. A wrong latched transmit sample shows on `dout_lo` at the first bit that differs inside the slot. A damaged receive shift register or bit count stays hidden until the end of the slot, and then shows as a wrong `rx_data` word or a missing or extra `rx_valid`. In master mode, a faulty divider or frame counter changes `bclk_out` or `fsync_out` within one bit clock or one frame.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int unsigned SMP_NARROW = 8;
  localparam int unsigned SMP_WIDE   = 16;

  typedef enum logic {
    FS_LONG  = 1'b0,
    FS_SHORT = 1'b1
  } fs_fmt_e;
endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      stage  <= 1'b1;
      rst_sn <= stage;
    end
  end
endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen #(
  parameter int FRAME_BITS = 256,
  parameter int HALF_DIV   = 2,
  parameter int BIT_W      = $clog2(FRAME_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  pcm_pkg::fs_fmt_e    fmt,
  input  logic                wide,
  output logic                bclk_o,
  output logic                fsync_o
);
  localparam int PC_W = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
  localparam logic [PC_W-1:0]  PC_LAST  = PC_W'(2 * HALF_DIV - 1);
  localparam logic [PC_W-1:0]  PC_RISE  = PC_W'(HALF_DIV);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic [PC_W-1:0]  pc, pc_n;
  logic [BIT_W-1:0] gbit, gbit_n, fs_len;
  logic             bclk_n, fsync_n;

  always_comb begin
    fs_len = wide ? BIT_W'(pcm_pkg::SMP_WIDE) : BIT_W'(pcm_pkg::SMP_NARROW);
    if (run) begin
      pc_n   = (pc == PC_LAST) ? '0 : pc + PC_W'(1);
      gbit_n = gbit;
      if (pc_n == PC_RISE) gbit_n = (gbit == BIT_LAST) ? '0 : gbit + BIT_W'(1);
      bclk_n  = (pc_n >= PC_RISE);
      fsync_n = (fmt == pcm_pkg::FS_SHORT) ? (gbit_n == BIT_LAST) : (gbit_n < fs_len);
    end else begin
      pc_n    = '0;
      gbit_n  = BIT_LAST;
      bclk_n  = 1'b0;
      fsync_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= '0;
      gbit    <= BIT_LAST;
      bclk_o  <= 1'b0;
      fsync_o <= 1'b0;
    end else begin
      pc      <= pc_n;
      gbit    <= gbit_n;
      bclk_o  <= bclk_n;
      fsync_o <= fsync_n;
    end
  end

  // R11: generator stopped means both clock lines are low on the next cycle
  p_pd_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!bclk_o && !fsync_o));
endmodule

// File: rtl/pcm_frame.sv
module pcm_frame #(
  parameter int FRAME_BITS = 256,
  parameter int BIT_W      = $clog2(FRAME_BITS),
  parameter int SW         = pcm_pkg::SMP_WIDE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                fs_i,
  input  pcm_pkg::fs_fmt_e    fmt,
  input  logic [SW-1:0]       tx_hold,
  output logic                fall,
  output logic [BIT_W-1:0]    bit_idx,
  output logic                in_frame,
  output logic [SW-1:0]       tx_smp
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic             bclk_q, fs_q, fs_fall, fs_fall_n;
  logic             rise, fstart, inf_n;
  logic [BIT_W-1:0] idx_n;
  logic [SW-1:0]    smp_n;

  always_comb begin
    rise      = bclk_i & ~bclk_q;
    fall      = ~bclk_i & bclk_q;
    fstart    = (fmt == pcm_pkg::FS_SHORT) ? (rise & fs_fall) : (fs_i & ~fs_q);
    fs_fall_n = fall ? fs_i : fs_fall;
    idx_n     = bit_idx;
    inf_n     = in_frame;
    smp_n     = tx_smp;
    if (fstart) begin
      idx_n = '0;
      inf_n = 1'b1;
      smp_n = tx_hold;
    end else if (rise && in_frame) begin
      if (bit_idx == BIT_LAST) inf_n = 1'b0;
      else                     idx_n = bit_idx + BIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      fs_q     <= 1'b0;
      fs_fall  <= 1'b0;
      bit_idx  <= '0;
      in_frame <= 1'b0;
      tx_smp   <= '0;
    end else begin
      bclk_q   <= bclk_i;
      fs_q     <= fs_i;
      fs_fall  <= fs_fall_n;
      bit_idx  <= idx_n;
      in_frame <= inf_n;
      tx_smp   <= smp_n;
    end
  end

  // R5: inside a frame the index only advances by one or restarts at zero
  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && $past(in_frame) && bit_idx != $past(bit_idx)) |->
      (bit_idx == $past(bit_idx) + BIT_W'(1) || bit_idx == '0));
endmodule

// File: rtl/pcm_slot_io.sv
module pcm_slot_io #(
  parameter int BIT_W = 8,
  parameter int SW    = pcm_pkg::SMP_WIDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pwrdn,
  input  logic              wide,
  input  logic [BIT_W-1:0]  slot_off,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              in_frame,
  input  logic [SW-1:0]     tx_smp,
  input  logic              fall,
  input  logic              din,
  output logic              tx_slot,
  output logic              dout_lo,
  output logic [SW-1:0]     rx_data,
  output logic              rx_valid
);
  localparam int SEL_W = $clog2(SW);
  localparam int NW    = pcm_pkg::SMP_NARROW;

  logic [BIT_W-1:0] offs, w_len;
  logic [SEL_W-1:0] sel;
  logic             hit, last;
  logic [SW-1:0]    rx_sh, rx_sh_n, rx_data_n;
  logic             rx_valid_n;

  always_comb begin
    w_len = wide ? BIT_W'(SW) : BIT_W'(NW);
    offs  = bit_idx - slot_off;
    hit   = in_frame & en & ~pwrdn & (bit_idx >= slot_off) & (offs < w_len);
    last  = (offs == w_len - BIT_W'(1));
    sel   = (wide ? SEL_W'(SW - 1) : SEL_W'(NW - 1)) - offs[SEL_W-1:0];
    tx_slot = hit;
    dout_lo = hit & ~tx_smp[sel];

    rx_sh_n    = rx_sh;
    rx_data_n  = rx_data;
    rx_valid_n = 1'b0;
    if (fall && hit) begin
      rx_sh_n = {rx_sh[SW-2:0], din};
      if (last) begin
        rx_valid_n = 1'b1;
        rx_data_n  = wide ? rx_sh_n : {{(SW-NW){1'b0}}, rx_sh_n[NW-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_sh    <= rx_sh_n;
      rx_data  <= rx_data_n;
      rx_valid <= rx_valid_n;
    end
  end

  // R8: the receive strobe lasts one cycle and follows a falling bit-clock edge
  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_valid_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(fall));
  // R10: a disabled or powered-down port raises no strobe
  p_quiet_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || pwrdn) |=> !rx_valid);
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port #(
  parameter int FRAME_BITS = 256,
  parameter int HALF_DIV   = 2,
  parameter int BIT_W      = $clog2(FRAME_BITS),
  parameter int SW         = pcm_pkg::SMP_WIDE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             short_fs,
  input  logic             wide,
  input  logic             en,
  input  logic             pwrdn,
  input  logic [BIT_W-1:0] slot_off,
  input  logic             bclk_in,
  input  logic             fsync_in,
  input  logic             din,
  input  logic [SW-1:0]    tx_hold,
  output logic             bclk_out,
  output logic             fsync_out,
  output logic             dout_lo,
  output logic             tx_slot,
  output logic [SW-1:0]    rx_data,
  output logic             rx_valid
);
  logic                rst_sn, run, bclk_i, fs_i, fall, in_frame;
  logic [BIT_W-1:0]    bit_idx;
  logic [SW-1:0]       tx_smp;
  pcm_pkg::fs_fmt_e    fmt;

  assign fmt    = pcm_pkg::fs_fmt_e'(short_fs);
  assign run    = master & ~pwrdn;
  assign bclk_i = master ? bclk_out  : bclk_in;
  assign fs_i   = master ? fsync_out : fsync_in;

  pcm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  pcm_clkgen #(.FRAME_BITS(FRAME_BITS), .HALF_DIV(HALF_DIV), .BIT_W(BIT_W)) u_gen (
    .clk(clk), .rst_n(rst_sn), .run(run), .fmt(fmt), .wide(wide),
    .bclk_o(bclk_out), .fsync_o(fsync_out));

  pcm_frame #(.FRAME_BITS(FRAME_BITS), .BIT_W(BIT_W), .SW(SW)) u_frame (
    .clk(clk), .rst_n(rst_sn), .bclk_i(bclk_i), .fs_i(fs_i), .fmt(fmt),
    .tx_hold(tx_hold), .fall(fall), .bit_idx(bit_idx), .in_frame(in_frame),
    .tx_smp(tx_smp));

  pcm_slot_io #(.BIT_W(BIT_W), .SW(SW)) u_slot (
    .clk(clk), .rst_n(rst_sn), .en(en), .pwrdn(pwrdn), .wide(wide),
    .slot_off(slot_off), .bit_idx(bit_idx), .in_frame(in_frame),
    .tx_smp(tx_smp), .fall(fall), .din(din), .tx_slot(tx_slot),
    .dout_lo(dout_lo), .rx_data(rx_data), .rx_valid(rx_valid));

  // R4: in slave mode the clock outputs stay low
  p_slave_quiet_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    !master |=> (!bclk_out && !fsync_out));
endmodule

// File: tb/tb_pcm_tdm_port.sv
`timescale 1ns/1ps
module tb_pcm_tdm_port;
  logic clk = 1'b0;
  logic rst_n, master, short_fs, wide, en, pwrdn, bclk_in, fsync_in, din;
  logic [7:0]  slot_off;
  logic [15:0] tx_hold;
  logic bclk_out, fsync_out, dout_lo, tx_slot, rx_valid;
  logic [15:0] rx_data;

  always #10 clk = ~clk;

  pcm_tdm_port dut (.*);

  int total = 0, bad = 0, cyc = 0;
  bit chk_on = 0, done = 0;
  int nvalid = 0, nslot = 0, nlo = 0, nclk = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model state
  int rcnt, bq, fq, ffall, idx, inf, txs, rxs, rxd, pc, gb, mbclk, mfs;
  int e_valid, e_slot, e_lo;

  task automatic mreset();
    bq = 0; fq = 0; ffall = 0; idx = 0; inf = 0; txs = 0; rxs = 0; rxd = 0;
    pc = 0; gb = 255; mbclk = 0; mfs = 0; e_valid = 0; e_slot = 0; e_lo = 0;
  endtask

  task automatic mstep();
    int bi, fi, rise, fall, fst, w, hit, k;
    w    = wide ? 16 : 8;
    bi   = master ? mbclk : bclk_in;
    fi   = master ? mfs : fsync_in;
    rise = bi && !bq;
    fall = !bi && bq;
    fst  = short_fs ? (rise && ffall) : (fi && !fq);
    hit  = inf && en && !pwrdn && idx >= slot_off && (idx - slot_off) < w;
    k    = idx - slot_off;
    e_valid = 0;
    if (fall && hit) begin
      rxs = ((rxs << 1) | din) & 16'hffff;
      if (k == w - 1) begin
        e_valid = 1;
        rxd = wide ? rxs : (rxs & 8'hff);
      end
    end
    if (fall) ffall = fi;
    bq = bi; fq = fi;
    if (fst) begin idx = 0; inf = 1; txs = tx_hold; end
    else if (rise && inf) begin
      if (idx == 255) inf = 0; else idx++;
    end
    if (master && !pwrdn) begin
      pc = (pc == 3) ? 0 : pc + 1;
      if (pc == 2) gb = (gb == 255) ? 0 : gb + 1;
      mbclk = (pc >= 2);
      mfs   = short_fs ? (gb == 255) : (gb < w);
    end else begin
      pc = 0; gb = 255; mbclk = 0; mfs = 0;
    end
    e_slot = inf && en && !pwrdn && idx >= slot_off && (idx - slot_off) < w;
    e_lo   = e_slot && !((txs >> (w - 1 - (idx - slot_off))) & 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin rcnt = 0; mreset(); end
    else if (rcnt < 2) begin rcnt++; mreset(); end
    else mstep();
    if (cyc > 150000 && !done) begin
      bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // per-cycle comparison against the model, plus port activity counters
  always @(negedge clk) begin
    if (rx_valid) nvalid++;
    if (tx_slot) nslot++;
    if (dout_lo) nlo++;
    if (bclk_out || fsync_out) nclk++;
    if (chk_on) begin
      chk(bclk_out == mbclk[0], "R2 bclk_out", bclk_out, mbclk);
      chk(fsync_out == mfs[0], "R3 fsync_out", fsync_out, mfs);
      chk(tx_slot == e_slot[0], "R5,R6 tx_slot", tx_slot, e_slot);
      chk(dout_lo == e_lo[0], "R7,R12 dout_lo", dout_lo, e_lo);
      chk(rx_valid == e_valid[0], "R8 rx_valid", rx_valid, e_valid);
      chk(rx_data == rxd[15:0], "R8 rx_data", rx_data, rxd);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic clr();
    nvalid = 0; nslot = 0; nlo = 0; nclk = 0;
  endtask

  logic [15:0] lf = 16'hACE1;
  initial begin
    din = 1'b0;
    forever begin
      step();
      din = lf[0];
      lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    end
  end

  task automatic sframe(input int nbits, input int half, input bit shortp);
    int w;
    w = wide ? 16 : 8;
    for (int b = 0; b < nbits; b++) begin
      step();
      bclk_in  = 1'b1;
      fsync_in = shortp ? (b == nbits - 1) : (b < w);
      if (b == 5) tx_hold = ~tx_hold;
      repeat (half) step();
      bclk_in = 1'b0;
      repeat (half - 1) step();
    end
  endtask

  task automatic meas(output int nb, output int fsh);
    bit pb, pf, fsdone;
    pf = fsync_out; step();
    while (!(fsync_out && !pf)) begin pf = fsync_out; step(); end
    nb = 0; fsh = 1; fsdone = 0; pb = bclk_out; pf = fsync_out;
    while (1) begin
      step();
      if (bclk_out && !pb) nb++;
      if (!fsdone) begin
        if (fsync_out) fsh++; else fsdone = 1;
      end
      if (fsync_out && !pf) break;
      pb = bclk_out; pf = fsync_out;
    end
  endtask

  initial begin
    int nb, fsh;
    rst_n = 1'b0; master = 1'b0; short_fs = 1'b0; wide = 1'b0; en = 1'b1;
    pwrdn = 1'b0; bclk_in = 1'b0; fsync_in = 1'b0; slot_off = 8'd3;
    tx_hold = 16'h5AC3;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R1: reset state at the ports
    chk(bclk_out == 0, "R1 bclk_out", bclk_out, 0);
    chk(fsync_out == 0, "R1 fsync_out", fsync_out, 0);
    chk(dout_lo == 0, "R1 dout_lo", dout_lo, 0);
    chk(tx_slot == 0, "R1 tx_slot", tx_slot, 0);
    chk(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
    chk(rx_data == 0, "R1 rx_data", rx_data, 0);
    chk_on = 1;

    // slave, long sync, 8-bit, slot at 3
    clr();
    for (int f = 0; f < 3; f++) begin tx_hold = tx_hold + 16'h1357; sframe(24, 3, 0); end
    repeat (4) step();
    chk(nvalid == 3, "R8 slave long strobes", nvalid, 3);
    chk(nclk == 0, "R4 clock outputs in slave", nclk, 0);

    // slave, short sync, 16-bit, slot at 5 (first frame has no preceding pulse)
    clr(); wide = 1'b1; short_fs = 1'b1; slot_off = 8'd5;
    for (int f = 0; f < 3; f++) begin tx_hold = tx_hold ^ 16'hA5F0; sframe(32, 3, 1); end
    repeat (4) step();
    chk(nvalid == 2, "R5 short sync frames received", nvalid, 2);

    // disabled port
    clr(); en = 1'b0; wide = 1'b0; short_fs = 1'b0; slot_off = 8'd2;
    for (int f = 0; f < 2; f++) sframe(24, 3, 0);
    repeat (4) step();
    chk(nslot == 0, "R10 slot with en=0", nslot, 0);
    chk(nlo == 0, "R10 drive with en=0", nlo, 0);
    chk(nvalid == 0, "R10 strobe with en=0", nvalid, 0);
    en = 1'b1;

    // master, long sync, 16-bit, slot at 0
    master = 1'b1; wide = 1'b1; slot_off = 8'd0; tx_hold = 16'h8E71;
    repeat (1100) step();
    meas(nb, fsh);
    chk(nb == 256, "R2 bit clocks per frame", nb, 256);
    chk(fsh == 64, "R3 long sync width", fsh, 64);

    // master, short sync, 8-bit, slot at 100
    short_fs = 1'b1; wide = 1'b0; slot_off = 8'd100;
    repeat (1100) step();
    meas(nb, fsh);
    chk(nb == 256, "R2 bit clocks per frame short", nb, 256);
    chk(fsh == 4, "R3 short sync width", fsh, 4);
    repeat (1100) step();

    // master, long sync, 16-bit, slot at 250 runs past the frame end
    short_fs = 1'b0; wide = 1'b1; slot_off = 8'd250;
    repeat (1100) step();
    clr();
    repeat (2100) step();
    chk(nvalid == 0, "R9 clipped slot strobes", nvalid, 0);
    chk(nslot > 0, "R9 clipped slot still driven", nslot, 1);

    // power-down in master mode
    pwrdn = 1'b1;
    repeat (2) step();
    clr();
    repeat (300) step();
    chk(nclk == 0, "R11 clocks in power-down", nclk, 0);
    chk(nslot == 0, "R11 slot in power-down", nslot, 0);

    // back to slave: clock outputs stay low
    pwrdn = 1'b0; master = 1'b0;
    repeat (2) step();
    clr();
    repeat (100) step();
    chk(nclk == 0, "R4 clocks after returning to slave", nclk, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule